// File: doc/BRIEF.md
# Invert-Select Arithmetic Logic Unit

A purely combinational arithmetic logic unit for a single-cycle datapath. Each bit position has one shared structure made of an AND gate, an OR gate, a full adder and a "less" input. Each operand can be inverted on its way into that structure. A 4-bit control word picks the result. Its top bit inverts operand A, the next bit inverts operand B, and the low two bits choose which path of the slice drives the result bit.

Subtraction has no dedicated unit. Inverting B also forces the carry into bit 0 high, so the adder forms A + ~B + 1. NOR is the AND path with both operands inverted. Set-on-less-than reuses the subtraction. The top slice returns the sign of the difference, corrected by the signed overflow, and this value is routed back into bit 0 of the result.

The unit also drives two flags. The zero flag is meant for branch decisions and reports an all-zero result. The overflow flag reports signed overflow, but only for the add and subtract codes.

Top module: `alu_invsel`

## Requirements
- R1: Control code 4'b0010 (add) gives result_o = a_i + b_i modulo 2^32.
- R2: Control code 4'b0110 (subtract) gives result_o = a_i - b_i modulo 2^32.
- R3: Control code 4'b0000 gives a_i & b_i, and control code 4'b0001 gives a_i | b_i.
- R4: Control code 4'b1100 gives ~(a_i | b_i).
- R5: Control code 4'b0111 (set-on-less-than) gives 1 in bit 0 and 0 in every other bit when a_i < b_i as signed two's-complement numbers. Otherwise it gives all zeros. The result stays correct when the subtraction overflows.
- R6: overflow_o is 1 only for codes 4'b0010 and 4'b0110, and only when the signed sum or difference does not fit in 32 bits. For every other code it is 0.
- R7: zero_o is 1 exactly when all 32 bits of result_o are 0. This holds for every control code.
- R8: Every one of the 16 codes follows the general rule below:
  - ctrl_i[3] inverts A and ctrl_i[2] inverts B.
  - The carry into bit 0 equals ctrl_i[2].
  - ctrl_i[1:0] selects the result: 00 gives the AND of the operands, 01 gives their OR, 10 gives the sum, and 11 gives the less value, which is the corrected sign of the sum placed in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| ctrl_i | input | 4 | Control word {invert A, invert B, operation[1:0]} |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | High when the result is all zeros |
| overflow_o | output | 1 | Signed overflow, add and subtract codes only |

## Verification
The checker module evaluates a set of properties whenever the inputs change:
- the zero flag matches the result;
- set-on-less-than leaves bits 31 to 1 clear;
- the overflow flag stays low outside add and subtract;
- the add, subtract and NOR codes produce their arithmetic or logic values.

Some behaviour can only be shown by the bench's chosen operands. These are the signed-overflow boundaries, set-on-less-than across an overflowing difference, and the undocumented codes that follow the general invert rule.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_SUM  = 2'b10,
    OP_LESS = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic    a_inv;
    logic    b_inv;
    alu_op_e op;
  } alu_ctrl_t;

  localparam logic [3:0] CTRL_AND = 4'b0000;
  localparam logic [3:0] CTRL_OR  = 4'b0001;
  localparam logic [3:0] CTRL_ADD = 4'b0010;
  localparam logic [3:0] CTRL_SUB = 4'b0110;
  localparam logic [3:0] CTRL_SLT = 4'b0111;
  localparam logic [3:0] CTRL_NOR = 4'b1100;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
#(
  parameter bit IS_MSB = 1'b0
) (
  input  logic    a_i,
  input  logic    b_i,
  input  logic    a_inv_i,
  input  logic    b_inv_i,
  input  logic    cin_i,
  input  logic    less_i,
  input  alu_op_e op_i,
  output logic    res_o,
  output logic    cout_o,
  output logic    set_o,
  output logic    ovf_o
);
  logic a_eff, b_eff, sum;

  assign a_eff  = a_i ^ a_inv_i;
  assign b_eff  = b_i ^ b_inv_i;
  assign sum    = a_eff ^ b_eff ^ cin_i;
  assign cout_o = (a_eff & b_eff) | (a_eff & cin_i) | (b_eff & cin_i);

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_eff & b_eff;
      OP_OR:   res_o = a_eff | b_eff;
      OP_SUM:  res_o = sum;
      default: res_o = less_i;
    endcase
  end

  generate
    if (IS_MSB) begin : g_msb
      assign ovf_o = cin_i ^ cout_o;
      assign set_o = sum ^ ovf_o;  // corrected sign
    end else begin : g_mid
      assign ovf_o = 1'b0;
      assign set_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] val_i,
  output logic             zero_o
);
  assign zero_o = (val_i == '0);
endmodule

// File: rtl/alu_invsel.sv
module alu_invsel
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       ctrl_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o
);
  localparam int MSB = WIDTH - 1;

  alu_ctrl_t       ctrl;
  logic [WIDTH:0]  carry;
  logic [WIDTH-1:0] set_v, ovf_v;
  logic            is_arith;

  assign ctrl     = alu_ctrl_t'(ctrl_i);
  assign carry[0] = ctrl.b_inv;  // A + ~B + 1 when B inverted

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      alu_slice #(.IS_MSB(i == MSB)) u_slice (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .a_inv_i (ctrl.a_inv),
        .b_inv_i (ctrl.b_inv),
        .cin_i   (carry[i]),
        .less_i  ((i == 0) ? set_v[MSB] : 1'b0),
        .op_i    (ctrl.op),
        .res_o   (result_o[i]),
        .cout_o  (carry[i+1]),
        .set_o   (set_v[i]),
        .ovf_o   (ovf_v[i])
      );
    end
  endgenerate

  assign is_arith   = (ctrl_i == CTRL_ADD) || (ctrl_i == CTRL_SUB);
  assign overflow_o = is_arith & ovf_v[MSB];

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .val_i  (result_o),
    .zero_o (zero_o)
  );
endmodule

// File: rtl/alu_invsel_chk.sv
module alu_invsel_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       ctrl_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             overflow_o
);
  always_comb begin
    // R7
    zero_flag_chk: assert (zero_o == (result_o == '0));
    // R5
    slt_shape_chk: assert (ctrl_i != CTRL_SLT || result_o[WIDTH-1:1] == '0);
    // R6
    no_overflow_chk: assert ((ctrl_i == CTRL_ADD) || (ctrl_i == CTRL_SUB) || !overflow_o);
    // R1
    add_value_chk: assert (ctrl_i != CTRL_ADD || result_o == a_i + b_i);
    // R2
    sub_value_chk: assert (ctrl_i != CTRL_SUB || result_o == a_i - b_i);
    // R4
    nor_value_chk: assert (ctrl_i != CTRL_NOR || result_o == ~(a_i | b_i));
  end
endmodule

bind alu_invsel alu_invsel_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu_invsel_tb.sv
module alu_invsel_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b, res;
  logic [3:0]  ctrl;
  logic        zero, ovf;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  alu_invsel u_dut (
    .a_i(a), .b_i(b), .ctrl_i(ctrl),
    .result_o(res), .zero_o(zero), .overflow_o(ovf)
  );

  // R8 general reference
  function automatic logic [33:0] ref_model(logic [31:0] x, logic [31:0] y, logic [3:0] c);
    logic [31:0] xe, ye, r;
    logic [32:0] s;
    logic        ov, lt, ovo;
    xe = c[3] ? ~x : x;
    ye = c[2] ? ~y : y;
    s  = {1'b0, xe} + {1'b0, ye} + {32'd0, c[2]};
    ov = (xe[31] == ye[31]) && (s[31] != xe[31]);
    lt = s[31] ^ ov;
    case (c[1:0])
      2'b00: r = xe & ye;
      2'b01: r = xe | ye;
      2'b10: r = s[31:0];
      default: r = {31'd0, lt};
    endcase
    ovo = ((c == 4'b0010) || (c == 4'b0110)) && ov;
    return {ovo, (r == 32'd0), r};
  endfunction

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [3:0] c,
                       input string tag);
    logic [33:0] e;
    @(negedge clk);
    a = x; b = y; ctrl = c;
    #5;
    e = ref_model(x, y, c);
    n_vec++;
    if (res !== e[31:0]) begin
      n_bad++;
      $display("FAIL %s result ctrl=%b a=%h b=%h act=%h exp=%h", tag, c, x, y, res, e[31:0]);
    end
    if (zero !== e[32]) begin
      n_bad++;
      $display("FAIL R7 zero ctrl=%b act=%b exp=%b", c, zero, e[32]);
    end
    if (ovf !== e[33]) begin
      n_bad++;
      $display("FAIL R6 overflow ctrl=%b a=%h b=%h act=%b exp=%b", c, x, y, ovf, e[33]);
    end
  endtask

  task automatic slt_direct(input logic [31:0] x, input logic [31:0] y);
    logic [31:0] e;
    apply(x, y, 4'b0111, "R5");
    e = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
    n_vec++;
    if (res !== e) begin
      n_bad++;
      $display("FAIL R5 signed compare a=%h b=%h act=%h exp=%h", x, y, res, e);
    end
  endtask

  initial begin
    a = '0; b = '0; ctrl = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: all-zero inputs, AND code
    apply(32'd0, 32'd0, 4'b0000, "R3");
    // R1 add
    apply(32'h7fffffff, 32'd1, 4'b0010, "R1");
    apply(32'hffffffff, 32'd1, 4'b0010, "R1");
    apply(32'h80000000, 32'h80000000, 4'b0010, "R1");
    // R2 sub
    apply(32'h80000000, 32'd1, 4'b0110, "R2");
    apply(32'h12345678, 32'h12345678, 4'b0110, "R2");
    apply(32'd0, 32'd1, 4'b0110, "R2");
    // R3 and/or
    apply(32'hf0f0a5a5, 32'h0ff05a5a, 4'b0000, "R3");
    apply(32'hf0f0a5a5, 32'h0ff05a5a, 4'b0001, "R3");
    // R4 nor
    apply(32'd0, 32'd0, 4'b1100, "R4");
    apply(32'hffff0000, 32'h0000fff0, 4'b1100, "R4");
    // R5 slt incl. overflowing differences
    slt_direct(32'h80000000, 32'd1);
    slt_direct(32'h7fffffff, 32'hffffffff);
    slt_direct(32'd5, 32'd5);
    slt_direct(32'hfffffffe, 32'hffffffff);
    // R8 every code
    for (int c = 0; c < 16; c++) apply(32'h8000ffff, 32'h7fff0001, c[3:0], "R8");
    // random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] x, y;
      logic [3:0]  c;
      x = $urandom(); y = $urandom(); c = 4'($urandom());
      if (k % 7 == 0) y = x;
      if (k % 4 == 0) begin
        case ($urandom_range(0, 5))
          0: c = 4'b0010; 1: c = 4'b0110; 2: c = 4'b0111;
          3: c = 4'b1100; 4: c = 4'b0000; default: c = 4'b0001;
        endcase
      end
      if (c == 4'b0111) slt_direct(x, y);
      else apply(x, y, c, "R8");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule